// File: doc/BRIEF.md
# Picture-in-Picture Window Compositor

This block generates the window timing that places a reduced sub-picture over a main video raster. It counts pixel clocks and lines from the main horizontal and vertical sync pulses, judges the field parity of the main raster, and estimates whether the raster runs at the 50 Hz line count. A programmable origin, a per-axis reduction ratio, a border and a mute control define the window.

For every pixel it produces a source code, fill levels for border and background pixels, a read strobe and column address for the sub-picture line store, and a main/sub switch signal. The switch signal can be delayed by a programmable number of pixels. A freeze control gates the sub-picture write strobe, so the stored picture holds still while display reads carry on.

Sync inputs are one-clock pulses at the pixel rate. The pixel and line counters restart on the clock after a pulse.

Top module: `pip_window_comp`

## Requirements
- R1: `sel_o` is high for a pixel only when that pixel is inside the sub-picture area, or inside the border ring with `border_en_i` set. With the default delay of 0, `sel_o` changes one clock after the counter value it reflects.
- R2: `src_o` encodes 0 = main, 1 = sub-picture, 2 = border, 3 = background. It is registered one clock after the counter value. Ring pixels never report sub-picture. Main and sub pixels carry zero fill levels.
- R3: The sub-picture area is W9 or W16 pixels wide (`size_h_i` = 0 or 1) and H9 or H16 lines tall (`size_v_i` = 0 or 1). The border ring is 2 pixels thick on the left and right and 1 line thick on the top and bottom. The outer box starts at pixel `pos_x_i` and line `pos_y_i`.
- R4: `rd_en_o` is high exactly for sub-picture pixels. `rd_addr_o` is then the column inside the area, from 0 to the active width minus 1.
- R5: With `mute_i` set, area pixels report background (3), their fill levels are the background levels, and `rd_en_o` stays low.
- R6: Border pixels use the edge levels when `edge_sep_i` is set and the background levels otherwise.
- R7: `rate50_o` is set at a vertical sync when the field that just ended counted at least RATE_THR lines. With `pos50_en_i` set and `rate50_o` high, the vertical origin is floor(`pos_y_i`*6/5).
- R8: A vertical sync at pixel position p of a line of measured length L sets the raw field to 1 when L/4 <= p < L - L/4, and to 0 otherwise. A vertical sync arriving together with a horizontal sync counts as p = 0. `field_o` is the raw field XOR `field_inv_i`, and `field_fix_i` forces it to 0.
- R9: `wr_en_o` equals `wr_req_i` while `freeze_i` is low, and is low while `freeze_i` is high. Reads are not affected by `freeze_i`.
- R10: `sel_o` is delayed by `sw_dly_i` clocks relative to `src_o`.
- R11: When `disp_en_i` is low, `sel_o` is low on the next clock and `src_o` reports main.
- R12: A window that extends past the end of a line is clipped. It does not reappear at the start of the line.
- R13: During reset, `sel_o`, `rd_en_o`, `src_o`, `field_o` and `rate50_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Main line-start pulse |
| vsync_i | input | 1 | Main field-start pulse |
| disp_en_i | input | 1 | Window display enable |
| size_h_i | input | 1 | Horizontal ratio: 0 = 1/9, 1 = 1/16 |
| size_v_i | input | 1 | Vertical ratio: 0 = 1/9, 1 = 1/16 |
| pos_x_i | input | POS_W | Window origin pixel |
| pos_y_i | input | POS_W | Window origin line |
| pos50_en_i | input | 1 | Enable 1.2x vertical origin on 50 Hz rasters |
| border_en_i | input | 1 | Border ring enable |
| edge_sep_i | input | 1 | Border uses its own levels |
| mute_i | input | 1 | Replace sub-picture with background |
| bg_y_i | input | 4 | Background luma level |
| bg_u_i | input | 3 | Background U level |
| bg_v_i | input | 3 | Background V level |
| edge_y_i | input | 4 | Border luma level |
| edge_u_i | input | 3 | Border U level |
| edge_v_i | input | 3 | Border V level |
| field_inv_i | input | 1 | Invert judged field |
| field_fix_i | input | 1 | Force field to 0 |
| sw_dly_i | input | DW | Switch output delay in pixels |
| freeze_i | input | 1 | Hold stored sub-picture |
| wr_req_i | input | 1 | Sub-picture write request |
| sel_o | output | 1 | Main/sub switch |
| src_o | output | 2 | Pixel source code |
| fill_y_o | output | 4 | Fill luma |
| fill_u_o | output | 3 | Fill U |
| fill_v_o | output | 3 | Fill V |
| rd_en_o | output | 1 | Line-store read strobe |
| rd_addr_o | output | AW | Line-store column address |
| wr_en_o | output | 1 | Gated write strobe |
| field_o | output | 1 | Main field parity |
| rate50_o | output | 1 | 50 Hz raster detected |

## Verification
The bench builds the block with CW = 10, a 12- or 9-pixel by 6- or 4-line window and RATE_THR = 20. It drives a raster of 40-pixel lines, so that every border edge, both reduction ratios and the 50 Hz origin scaling fall within a few hundred clocks of each probe. With these short fields, a 24-line field crosses the rate threshold and a 5-line field stays under it. A 40-pixel line places the parity quarter boundaries at pixels 10 and 30. A window origin of 30 runs the sub-picture area past the line end, which exercises the clipping.

// File: rtl/pip_pkg.sv
package pip_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN   = 2'd0,
    SRC_SUB    = 2'd1,
    SRC_BORDER = 2'd2,
    SRC_BACK   = 2'd3
  } src_e;

  localparam int BORDER_X = 2;
  localparam int BORDER_Y = 1;
  localparam int LVL_Y_W  = 4;
  localparam int LVL_C_W  = 3;
endpackage

// File: rtl/pip_raster_timer.sv
module pip_raster_timer #(
  parameter int CW       = 11,
  parameter int RATE_THR = 288
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          field_inv_i,
  input  logic          field_fix_i,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] vcnt_o,
  output logic          field_o,
  output logic          rate50_o
);
  logic [CW-1:0] hcnt_q, vcnt_q, len_q;
  logic          field_q, rate_q;
  logic [CW-1:0] vpos, quarter;
  logic          mid;

  assign vpos    = hsync_i ? '0 : hcnt_q;
  assign quarter = len_q >> 2;
  assign mid     = (vpos >= quarter) && (vpos < len_q - quarter);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      len_q   <= '0;
      field_q <= 1'b0;
      rate_q  <= 1'b0;
    end else begin
      if (hsync_i) begin
        hcnt_q <= '0;
        len_q  <= hcnt_q + CW'(1);
      end else if (hcnt_q != '1) begin
        hcnt_q <= hcnt_q + CW'(1);
      end
      if (vsync_i) begin
        vcnt_q  <= '0;
        field_q <= mid;
        rate_q  <= (vcnt_q >= CW'(RATE_THR));
      end else if (hsync_i && vcnt_q != '1) begin
        vcnt_q <= vcnt_q + CW'(1);
      end
    end
  end

  assign hcnt_o   = hcnt_q;
  assign vcnt_o   = vcnt_q;
  assign field_o  = field_fix_i ? 1'b0 : (field_q ^ field_inv_i);
  assign rate50_o = rate_q;
endmodule

// File: rtl/pip_window_geom.sv
module pip_window_geom
  import pip_pkg::*;
#(
  parameter int CW    = 11,
  parameter int POS_W = 8,
  parameter int W9    = 229,
  parameter int W16   = 172,
  parameter int H9    = 69,
  parameter int H16   = 52,
  parameter int AW    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CW-1:0]      hcnt_i,
  input  logic [CW-1:0]      vcnt_i,
  input  logic               disp_en_i,
  input  logic               size_h_i,
  input  logic               size_v_i,
  input  logic [POS_W-1:0]   pos_x_i,
  input  logic [POS_W-1:0]   pos_y_i,
  input  logic               scale_y_i,
  input  logic               border_en_i,
  input  logic               edge_sep_i,
  input  logic               mute_i,
  input  logic [LVL_Y_W-1:0] bg_y_i,
  input  logic [LVL_C_W-1:0] bg_u_i,
  input  logic [LVL_C_W-1:0] bg_v_i,
  input  logic [LVL_Y_W-1:0] edge_y_i,
  input  logic [LVL_C_W-1:0] edge_u_i,
  input  logic [LVL_C_W-1:0] edge_v_i,
  output logic               sel_raw_o,
  output src_e               src_o,
  output logic [LVL_Y_W-1:0] fill_y_o,
  output logic [LVL_C_W-1:0] fill_u_o,
  output logic [LVL_C_W-1:0] fill_v_o,
  output logic               rd_en_o,
  output logic [AW-1:0]      rd_addr_o
);
  localparam int SW  = CW + 2;
  localparam int PW3 = POS_W + 3;

  logic [PW3-1:0] py6, py_s;
  logic [SW-1:0]  x0, y0, wsz, hsz, hx, vy, col;
  logic           box_h, box_v, in_h, in_v, in_box, in_area;
  src_e           src_d;

  assign py6  = PW3'(pos_y_i) * PW3'(6);
  assign py_s = py6 / PW3'(5);

  assign x0  = SW'(pos_x_i);
  assign y0  = scale_y_i ? SW'(py_s) : SW'(pos_y_i);
  assign wsz = size_h_i ? SW'(W16) : SW'(W9);
  assign hsz = size_v_i ? SW'(H16) : SW'(H9);
  assign hx  = SW'(hcnt_i);
  assign vy  = SW'(vcnt_i);

  assign box_h   = (hx >= x0) && (hx < x0 + wsz + SW'(2 * BORDER_X));
  assign box_v   = (vy >= y0) && (vy < y0 + hsz + SW'(2 * BORDER_Y));
  assign in_h    = (hx >= x0 + SW'(BORDER_X)) && (hx < x0 + SW'(BORDER_X) + wsz);
  assign in_v    = (vy >= y0 + SW'(BORDER_Y)) && (vy < y0 + SW'(BORDER_Y) + hsz);
  assign in_box  = box_h && box_v;
  assign in_area = in_h && in_v;
  assign col     = hx - x0 - SW'(BORDER_X);

  assign sel_raw_o = in_area || (in_box && border_en_i);

  always_comb begin
    if (!disp_en_i)                    src_d = SRC_MAIN;
    else if (in_area)                  src_d = mute_i ? SRC_BACK : SRC_SUB;
    else if (in_box && border_en_i)    src_d = SRC_BORDER;
    else                               src_d = SRC_MAIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o     <= SRC_MAIN;
      fill_y_o  <= '0;
      fill_u_o  <= '0;
      fill_v_o  <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      src_o   <= src_d;
      rd_en_o <= (src_d == SRC_SUB);
      if (src_d == SRC_SUB) rd_addr_o <= AW'(col);
      unique case (src_d)
        SRC_BORDER: begin
          fill_y_o <= edge_sep_i ? edge_y_i : bg_y_i;
          fill_u_o <= edge_sep_i ? edge_u_i : bg_u_i;
          fill_v_o <= edge_sep_i ? edge_v_i : bg_v_i;
        end
        SRC_BACK: begin
          fill_y_o <= bg_y_i;
          fill_u_o <= bg_u_i;
          fill_v_o <= bg_v_i;
        end
        default: begin
          fill_y_o <= '0;
          fill_u_o <= '0;
          fill_v_o <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pip_switch_delay.sv
module pip_switch_delay #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [DW-1:0] dly_i,
  input  logic          disp_en_i,
  output logic          sel_o
);
  localparam int NT = (1 << DW) - 1;

  logic [NT-1:0] hist_q;
  logic [NT:0]   taps;

  assign taps = {hist_q, sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      sel_o  <= 1'b0;
    end else begin
      hist_q <= {hist_q[NT-2:0], sel_i};
      sel_o  <= disp_en_i && taps[dly_i];
    end
  end
endmodule

// File: rtl/pip_window_comp.sv
module pip_window_comp
  import pip_pkg::*;
#(
  parameter int CW       = 11,
  parameter int POS_W    = 8,
  parameter int W9       = 229,
  parameter int W16      = 172,
  parameter int H9       = 69,
  parameter int H16      = 52,
  parameter int RATE_THR = 288,
  parameter int DW       = 4,
  parameter int AW       = $clog2(W9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             disp_en_i,
  input  logic             size_h_i,
  input  logic             size_v_i,
  input  logic [POS_W-1:0] pos_x_i,
  input  logic [POS_W-1:0] pos_y_i,
  input  logic             pos50_en_i,
  input  logic             border_en_i,
  input  logic             edge_sep_i,
  input  logic             mute_i,
  input  logic [3:0]       bg_y_i,
  input  logic [2:0]       bg_u_i,
  input  logic [2:0]       bg_v_i,
  input  logic [3:0]       edge_y_i,
  input  logic [2:0]       edge_u_i,
  input  logic [2:0]       edge_v_i,
  input  logic             field_inv_i,
  input  logic             field_fix_i,
  input  logic [DW-1:0]    sw_dly_i,
  input  logic             freeze_i,
  input  logic             wr_req_i,
  output logic             sel_o,
  output logic [1:0]       src_o,
  output logic [3:0]       fill_y_o,
  output logic [2:0]       fill_u_o,
  output logic [2:0]       fill_v_o,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wr_en_o,
  output logic             field_o,
  output logic             rate50_o
);
  logic [CW-1:0] hcnt, vcnt;
  logic          rate50, sel_raw;
  src_e          src;

  pip_raster_timer #(.CW(CW), .RATE_THR(RATE_THR)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .field_inv_i (field_inv_i),
    .field_fix_i (field_fix_i),
    .hcnt_o      (hcnt),
    .vcnt_o      (vcnt),
    .field_o     (field_o),
    .rate50_o    (rate50)
  );

  pip_window_geom #(
    .CW(CW), .POS_W(POS_W), .W9(W9), .W16(W16), .H9(H9), .H16(H16), .AW(AW)
  ) i_geom (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hcnt_i      (hcnt),
    .vcnt_i      (vcnt),
    .disp_en_i   (disp_en_i),
    .size_h_i    (size_h_i),
    .size_v_i    (size_v_i),
    .pos_x_i     (pos_x_i),
    .pos_y_i     (pos_y_i),
    .scale_y_i   (pos50_en_i && rate50),
    .border_en_i (border_en_i),
    .edge_sep_i  (edge_sep_i),
    .mute_i      (mute_i),
    .bg_y_i      (bg_y_i),
    .bg_u_i      (bg_u_i),
    .bg_v_i      (bg_v_i),
    .edge_y_i    (edge_y_i),
    .edge_u_i    (edge_u_i),
    .edge_v_i    (edge_v_i),
    .sel_raw_o   (sel_raw),
    .src_o       (src),
    .fill_y_o    (fill_y_o),
    .fill_u_o    (fill_u_o),
    .fill_v_o    (fill_v_o),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o)
  );

  pip_switch_delay #(.DW(DW)) i_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_raw),
    .dly_i     (sw_dly_i),
    .disp_en_i (disp_en_i),
    .sel_o     (sel_o)
  );

  assign src_o    = src;
  assign rate50_o = rate50;
  assign wr_en_o  = wr_req_i && !freeze_i;
endmodule

// File: rtl/pip_window_comp_chk.sv
module pip_window_comp_chk #(
  parameter int W9 = 229,
  parameter int AW = 8,
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          disp_en_i,
  input logic [DW-1:0] sw_dly_i,
  input logic [3:0]    bg_y_i,
  input logic          freeze_i,
  input logic          field_fix_i,
  input logic          sel_o,
  input logic [1:0]    src_o,
  input logic [3:0]    fill_y_o,
  input logic [2:0]    fill_u_o,
  input logic [2:0]    fill_v_o,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wr_en_o,
  input logic          field_o
);
  p_fill_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 2'd0 || src_o == 2'd1) |-> (fill_y_o == '0 && fill_u_o == '0 && fill_v_o == '0));

  p_rd_sub_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o == (src_o == 2'd1));

  p_addr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> ({1'b0, rd_addr_o} < (AW+1)'(W9)));

  p_mute_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 2'd3) |-> (fill_y_o == $past(bg_y_i)));

  p_field_fix_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_fix_i |-> !field_o);

  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |-> !wr_en_o);

  p_no_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sw_dly_i) == '0) |-> (sel_o == (src_o != 2'd0)));

  p_disp_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(disp_en_i) |-> (!sel_o && src_o == 2'd0));
endmodule

bind pip_window_comp pip_window_comp_chk #(.W9(W9), .AW(AW), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .disp_en_i   (disp_en_i),
  .sw_dly_i    (sw_dly_i),
  .bg_y_i      (bg_y_i),
  .freeze_i    (freeze_i),
  .field_fix_i (field_fix_i),
  .sel_o       (sel_o),
  .src_o       (src_o),
  .fill_y_o    (fill_y_o),
  .fill_u_o    (fill_u_o),
  .fill_v_o    (fill_v_o),
  .rd_en_o     (rd_en_o),
  .rd_addr_o   (rd_addr_o),
  .wr_en_o     (wr_en_o),
  .field_o     (field_o)
);

// File: tb/test_pip_window_comp.sv
module test_pip_window_comp;
  localparam int LEN = 40;
  localparam int AW  = 4;
  localparam logic [1:0] S_MAIN = 2'd0, S_SUB = 2'd1, S_BRD = 2'd2, S_BCK = 2'd3;

  typedef struct packed {
    logic sh, sv, be, mu, es, p50;
    logic [7:0] px, py;
    logic [5:0] prep;
    logic [7:0] x, y;
    logic [1:0] src;
    logic [3:0] addr;
    logic [3:0] fy;
  } vec_t;

  // Window at (8,10), 12x6 area: box x 8..23 y 10..17, area x 10..21 y 11..16
  localparam vec_t VT [20] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd10, 8'd11, S_SUB, 4'd0,  4'd0},  // R1 R3 R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd21, 8'd16, S_SUB, 4'd11, 4'd0},  // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd9,  8'd12, S_BRD, 4'd0,  4'd5},  // R6
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'd8, 8'd10, 6'd2,  8'd9,  8'd12, S_BRD, 4'd0,  4'd12}, // R6
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd22, 8'd12, S_MAIN,4'd0,  4'd0},  // R1
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd15, 8'd10, S_BRD, 4'd0,  4'd5},  // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd15, 8'd17, S_BRD, 4'd0,  4'd5},  // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd7,  8'd12, S_MAIN,4'd0,  4'd0},  // R1
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd24, 8'd12, S_MAIN,4'd0,  4'd0},  // R1
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd15, 8'd18, S_MAIN,4'd0,  4'd0},  // R3
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd12, 8'd13, S_BCK, 4'd0,  4'd5},  // R5
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd18, 8'd12, S_SUB, 4'd8,  4'd0},  // R3
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd19, 8'd12, S_BRD, 4'd0,  4'd5},  // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd12, 8'd15, S_BRD, 4'd0,  4'd5},  // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd8, 8'd10, 6'd2,  8'd12, 8'd16, S_MAIN,4'd0,  4'd0},  // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 8'd8, 8'd10, 6'd24, 8'd12, 8'd12, S_BRD, 4'd0,  4'd5},  // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 8'd8, 8'd10, 6'd24, 8'd12, 8'd13, S_SUB, 4'd2,  4'd0},  // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 8'd8, 8'd10, 6'd5,  8'd12, 8'd12, S_SUB, 4'd2,  4'd0},  // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd30,8'd2,  6'd2,  8'd39, 8'd5,  S_SUB, 4'd7,  4'd0},  // R12
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd30,8'd2,  6'd2,  8'd1,  8'd5,  S_MAIN,4'd0,  4'd0}   // R12
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0, disp_en_i = 1'b1;
  logic size_h_i = 1'b0, size_v_i = 1'b0, pos50_en_i = 1'b0;
  logic border_en_i = 1'b1, edge_sep_i = 1'b0, mute_i = 1'b0;
  logic [7:0] pos_x_i = 8'd8, pos_y_i = 8'd10;
  logic [3:0] bg_y_i = 4'd5, edge_y_i = 4'd12;
  logic [2:0] bg_u_i = 3'd3, bg_v_i = 3'd2, edge_u_i = 3'd6, edge_v_i = 3'd1;
  logic field_inv_i = 1'b0, field_fix_i = 1'b0, freeze_i = 1'b0, wr_req_i = 1'b0;
  logic [3:0] sw_dly_i = 4'd0;
  logic sel_o, rd_en_o, wr_en_o, field_o, rate50_o;
  logic [1:0] src_o;
  logic [3:0] fill_y_o;
  logic [2:0] fill_u_o, fill_v_o;
  logic [AW-1:0] rd_addr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pip_window_comp #(
    .CW(10), .POS_W(8), .W9(12), .W16(9), .H9(6), .H16(4), .RATE_THR(20), .DW(4), .AW(AW)
  ) i_pip_window_comp (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic h, input logic v);
    @(negedge clk_i);
    hsync_i = h;
    vsync_i = v;
  endtask

  task automatic lines(input int n);
    tick(1'b1, 1'b1);
    for (int l = 0; l < n; l++) begin
      repeat (LEN - 1) tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
    end
  endtask

  // leaves outputs reflecting counter position (x,y), sampled at a negedge
  task automatic goto(input int x, input int y);
    lines(y);
    repeat (x) tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge clk_i);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk("R13 sel", sel_o, 0);
    chk("R13 src", src_o, S_MAIN);
    chk("R13 rd_en", rd_en_o, 0);
    chk("R13 field", field_o, 0);
    chk("R13 rate", rate50_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 20; i++) begin
      vec_t v = VT[i];
      logic [2:0] eu;
      size_h_i = v.sh; size_v_i = v.sv; border_en_i = v.be; mute_i = v.mu;
      edge_sep_i = v.es; pos50_en_i = v.p50; pos_x_i = v.px; pos_y_i = v.py;
      lines(int'(v.prep));
      goto(int'(v.x), int'(v.y));
      eu = (v.src == S_BRD) ? (v.es ? 3'd6 : 3'd3) : (v.src == S_BCK) ? 3'd3 : 3'd0;
      chk($sformatf("R2 src vec %0d", i), src_o, v.src);
      chk($sformatf("R1 sel vec %0d", i), sel_o, v.src != S_MAIN);
      chk($sformatf("R4 rd_en vec %0d", i), rd_en_o, v.src == S_SUB);
      if (v.src == S_SUB) chk($sformatf("R4 addr vec %0d", i), rd_addr_o, v.addr);
      chk($sformatf("R6 fill_y vec %0d", i), fill_y_o, v.fy);
      chk($sformatf("R5 fill_u vec %0d", i), fill_u_o, eu);
      chk($sformatf("R7 rate vec %0d", i), rate50_o, v.prep >= 6'd20);
    end
    size_h_i = 0; size_v_i = 0; border_en_i = 1; mute_i = 0; edge_sep_i = 0;
    pos50_en_i = 0; pos_x_i = 8'd8; pos_y_i = 8'd10;

    // R11 display off takes effect on the next pixel
    goto(12, 12);
    chk("R11 sel before", sel_o, 1);
    disp_en_i = 1'b0;
    @(negedge clk_i);
    chk("R11 sel off", sel_o, 0);
    chk("R11 src off", src_o, S_MAIN);
    disp_en_i = 1'b1;

    // R10 switch delay of 3 pixels
    sw_dly_i = 4'd3;
    goto(10, 12);
    chk("R10 src undelayed", src_o, S_SUB);
    chk("R10 sel delayed low", sel_o, 0);
    goto(11, 12);
    chk("R10 sel delayed high", sel_o, 1);
    sw_dly_i = 4'd0;

    // R9 freeze gates writes only
    goto(12, 12);
    wr_req_i = 1'b1;
    #1 chk("R9 write open", wr_en_o, 1);
    freeze_i = 1'b1;
    #1 chk("R9 write frozen", wr_en_o, 0);
    chk("R9 read continues", rd_en_o, 1);
    freeze_i = 1'b0; wr_req_i = 1'b0;

    // R8 field parity from vertical sync position
    goto(0, 2);
    repeat (9) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    @(negedge clk_i);
    chk("R8 vsync at quarter", field_o, 1);
    repeat (18) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    @(negedge clk_i);
    chk("R8 vsync at three quarters", field_o, 0);
    goto(0, 2);
    repeat (9) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    chk("R8 raw one", field_o, 1);
    field_inv_i = 1'b1;
    #1 chk("R8 invert", field_o, 0);
    field_inv_i = 1'b0; field_fix_i = 1'b1;
    #1 chk("R8 fixed", field_o, 0);
    field_fix_i = 1'b0;
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    chk("R8 line start", field_o, 0);
    field_inv_i = 1'b1;
    #1 chk("R8 invert start", field_o, 1);
    field_inv_i = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule